// File: doc/BRIEF.md
# Microprocessor Firmware Boot Sequencer

This block is a register-bus master that brings an embedded microprocessor out of reset with freshly loaded firmware. After a start pulse it asks the processor's identity register whether firmware is already running; if so it finishes at once. If not, it freezes the processor, and streams two memory images through a word-wide mailbox loader that sits behind 16-bit registers. The data image goes first, then the instruction image. After each image it reads back the loader's running CRC and compares it with its own.

When both images are in place, it clears the global soft-reset and low-power controls with a read-modify-write. It then drives the processor's reset while it is still frozen, holds that state for a timed minimum, and finally releases the processor. The image words come from an external source that the sequencer indexes by segment and word number. The image lengths arrive in bytes with the start pulse. Every bus transaction waits for its acknowledge. The outcome is reported as a one-cycle done or error pulse.

Top module: `fw_boot_seq`

## Requirements
- R1: A start with either segment length not a multiple of 4 bytes (low two bits nonzero) raises error in the cycle after start and issues no bus transaction.
- R2: The first transaction is a read of register 0x0020. A nonzero value ends the sequence with a done pulse and no further transactions.
- R3: If the value read is zero, the next transaction writes 0x0041 to register 0xC001 (bit 0 freezes the processor, bit 6 overrides its run control).
- R4: The data segment loads first, at mailbox address 0x3FFE0000, and the instruction segment loads second, at 0x40000000. Each segment opens with three writes: 0x1000 to 0x0200 (CRC clear), the address's upper half to 0x0202, and its lower half with bits 1:0 zeroed to 0x0203.
- R5: Word k of a segment is fetched with src_seg (0 = data, 1 = instruction) and src_idx = k. It is sent as three writes: word[31:16] to 0x0204, word[15:0] to 0x0205, then 0xC000 to 0x0200 (execute plus write). Word 0 goes first.
- R6: After the last word of a segment, the sequencer reads 0x0201 and compares the value with a CRC-16 computed over the segment's words. The CRC uses polynomial 0x1021 and initial value 0, and processes each word most significant byte first, each byte MSB first. A mismatch raises error and issues no further transaction.
- R7: After both segments, the sequencer reads register 0x0000 and writes the same value back with bits 15 and 11 cleared.
- R8: It then writes 0x8041 to 0xC001 (bit 15 adds processor reset) and issues nothing for at least ceil(CLK_HZ/1e6)*HOLD_US cycles. It then writes 0x0040 to 0xC001 and raises done.
- R9: While bus_req is high and bus_ack is low, bus_req, bus_we, bus_addr and bus_wdata stay unchanged. A transaction completes in the cycle where bus_req and bus_ack are both high.
- R10: done and error are single-cycle pulses, never high together, with exactly one per accepted start. A start while a sequence runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a boot sequence (taken only when idle) |
| seg0_len | input | LEN_W | Data segment length in bytes |
| seg1_len | input | LEN_W | Instruction segment length in bytes |
| src_seg | output | 1 | Segment of the word requested from the source |
| src_idx | output | LEN_W-2 | Word index requested from the source |
| src_word | input | 32 | Requested image word, valid in the same cycle |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Transaction acknowledge |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| done | output | 1 | One-cycle pulse on successful finish or skip |
| error | output | 1 | One-cycle pulse on length or CRC failure |

## Verification
The embedded properties check every cycle that the bus request is held stable until acknowledge, that done and error are lone single-cycle pulses, and that a misaligned start, a nonzero identity read or a CRC mismatch ends the sequence at once. They also check that the release write never comes sooner than the hold window after the reset write. The exact order of register writes, the image words on the bus, the read-modify-write of the global register and the CRC arithmetic can only be shown by the bench. It compares each recorded bus transaction with a sequence it builds itself, against a responder whose acknowledge latency varies.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

    // register map of the target processor subsystem
    localparam logic [15:0] A_FW_ID   = 16'h0020;
    localparam logic [15:0] A_UP_CTL  = 16'hC001;
    localparam logic [15:0] A_GLB_SC  = 16'h0000;
    localparam logic [15:0] A_MB_CMD  = 16'h0200;
    localparam logic [15:0] A_MB_CRC  = 16'h0201;
    localparam logic [15:0] A_MB_AHI  = 16'h0202;
    localparam logic [15:0] A_MB_ALO  = 16'h0203;
    localparam logic [15:0] A_MB_DHI  = 16'h0204;
    localparam logic [15:0] A_MB_DLO  = 16'h0205;

    // processor control bits
    localparam logic [15:0] UP_FREEZE = 16'h0001;
    localparam logic [15:0] UP_OVR    = 16'h0040;
    localparam logic [15:0] UP_RST    = 16'h8000;

    // mailbox commands and global control mask
    localparam logic [15:0] MB_CRC_CLR = 16'h1000;
    localparam logic [15:0] MB_EXEC_WR = 16'hC000;
    localparam logic [15:0] SC_CLR_MSK = 16'h8800;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ID_RD, ST_FREEZE, ST_CRC_CLR, ST_ADR_HI, ST_ADR_LO,
        ST_DAT_HI, ST_DAT_LO, ST_EXEC, ST_CRC_RD, ST_SC_RD, ST_SC_WR,
        ST_RST_ON, ST_HOLD, ST_RELEASE
    } boot_state_e;

    typedef struct packed {
        logic        req;
        logic        we;
        logic [15:0] addr;
        logic [15:0] wdata;
    } bus_cmd_t;

    function automatic logic [31:0] seg_base(input logic s);
        return s ? 32'h4000_0000 : 32'h3FFE_0000;
    endfunction

    // CRC-16, poly 0x1021, one 32-bit word, bit 31 first
    function automatic logic [15:0] crc16_word(input logic [15:0] c,
                                                input logic [31:0] w);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 31; i >= 0; i--) begin
            fb = r[15] ^ w[i];
            r  = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return r;
    endfunction

endpackage

// File: rtl/fwb_crc16.sv
module fwb_crc16 (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        upd,
    input  logic [31:0] word,
    output logic [15:0] crc
);
    import fwb_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clr) crc <= '0;
        else if (upd)   crc <= crc16_word(crc, word);
    end

    AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc == 16'h0000)); // R6

endmodule

// File: rtl/fwb_hold_timer.sv
module fwb_hold_timer #(
    parameter int LIM = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIM + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || arm)             cnt <= '0;
        else if (run && !expired)   cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(LIM - 1));

    AST_TIMER_LEAVES: assert property (@(posedge clk) disable iff (rst)
        expired |=> !run); // R8

endmodule

// File: rtl/fw_boot_seq.sv
module fw_boot_seq #(
    parameter int LEN_W   = 16,
    parameter int CLK_HZ  = 200_000_000,
    parameter int HOLD_US = 100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [LEN_W-1:0]   seg0_len,
    input  logic [LEN_W-1:0]   seg1_len,
    output logic               src_seg,
    output logic [LEN_W-3:0]   src_idx,
    input  logic [31:0]        src_word,
    output logic               bus_req,
    output logic               bus_we,
    output logic [15:0]        bus_addr,
    output logic [15:0]        bus_wdata,
    input  logic               bus_ack,
    input  logic [15:0]        bus_rdata,
    output logic               done,
    output logic               error
);
    import fwb_pkg::*;

    localparam int IDX_W    = LEN_W - 2;
    localparam int CYC_US   = (CLK_HZ + 999_999) / 1_000_000;
    localparam int HOLD_RAW = CYC_US * HOLD_US;
    localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

    boot_state_e      state;
    bus_cmd_t         cmd;
    logic             seg;
    logic [IDX_W-1:0] idx, n0, n1, cur_n;
    logic [15:0]      sc_val;
    logic [31:0]      base;
    logic [15:0]      crc_val;
    logic             xfer, misaligned, hold_done;
    logic             done_q, err_q;

    assign xfer       = cmd.req && bus_ack;
    assign misaligned = (|seg0_len[1:0]) || (|seg1_len[1:0]);
    assign cur_n      = seg ? n1 : n0;
    assign base       = seg_base(seg);

    // bus command decoded from the current state
    always_comb begin
        cmd = '{req: 1'b0, we: 1'b0, addr: 16'h0000, wdata: 16'h0000};
        case (state)
            ST_ID_RD:   cmd = '{1'b1, 1'b0, A_FW_ID,  16'h0000};
            ST_FREEZE:  cmd = '{1'b1, 1'b1, A_UP_CTL, UP_FREEZE | UP_OVR};
            ST_CRC_CLR: cmd = '{1'b1, 1'b1, A_MB_CMD, MB_CRC_CLR};
            ST_ADR_HI:  cmd = '{1'b1, 1'b1, A_MB_AHI, base[31:16]};
            ST_ADR_LO:  cmd = '{1'b1, 1'b1, A_MB_ALO, base[15:0] & 16'hFFFC};
            ST_DAT_HI:  cmd = '{1'b1, 1'b1, A_MB_DHI, src_word[31:16]};
            ST_DAT_LO:  cmd = '{1'b1, 1'b1, A_MB_DLO, src_word[15:0]};
            ST_EXEC:    cmd = '{1'b1, 1'b1, A_MB_CMD, MB_EXEC_WR};
            ST_CRC_RD:  cmd = '{1'b1, 1'b0, A_MB_CRC, 16'h0000};
            ST_SC_RD:   cmd = '{1'b1, 1'b0, A_GLB_SC, 16'h0000};
            ST_SC_WR:   cmd = '{1'b1, 1'b1, A_GLB_SC, sc_val};
            ST_RST_ON:  cmd = '{1'b1, 1'b1, A_UP_CTL, UP_FREEZE | UP_OVR | UP_RST};
            ST_RELEASE: cmd = '{1'b1, 1'b1, A_UP_CTL, UP_OVR};
            default:    ;
        endcase
    end

    assign bus_req   = cmd.req;
    assign bus_we    = cmd.we;
    assign bus_addr  = cmd.addr;
    assign bus_wdata = cmd.wdata;
    assign src_seg   = seg;
    assign src_idx   = idx;
    assign done      = done_q;
    assign error     = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            seg    <= 1'b0;
            idx    <= '0;
            n0     <= '0;
            n1     <= '0;
            sc_val <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    if (misaligned) err_q <= 1'b1;
                    else begin
                        n0    <= seg0_len[LEN_W-1:2];
                        n1    <= seg1_len[LEN_W-1:2];
                        seg   <= 1'b0;
                        state <= ST_ID_RD;
                    end
                end
                ST_ID_RD: if (xfer) begin
                    if (bus_rdata != 16'h0000) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else state <= ST_FREEZE;
                end
                ST_FREEZE:  if (xfer) state <= ST_CRC_CLR;
                ST_CRC_CLR: if (xfer) begin
                    idx   <= '0;
                    state <= ST_ADR_HI;
                end
                ST_ADR_HI:  if (xfer) state <= ST_ADR_LO;
                ST_ADR_LO:  if (xfer) state <= (cur_n == '0) ? ST_CRC_RD : ST_DAT_HI;
                ST_DAT_HI:  if (xfer) state <= ST_DAT_LO;
                ST_DAT_LO:  if (xfer) state <= ST_EXEC;
                ST_EXEC: if (xfer) begin
                    idx   <= idx + 1'b1;
                    state <= ((idx + 1'b1) == cur_n) ? ST_CRC_RD : ST_DAT_HI;
                end
                ST_CRC_RD: if (xfer) begin
                    if (bus_rdata != crc_val) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end else if (!seg) begin
                        seg   <= 1'b1;
                        state <= ST_CRC_CLR;
                    end else state <= ST_SC_RD;
                end
                ST_SC_RD: if (xfer) begin
                    sc_val <= bus_rdata & ~SC_CLR_MSK;
                    state  <= ST_SC_WR;
                end
                ST_SC_WR:  if (xfer) state <= ST_RST_ON;
                ST_RST_ON: if (xfer) state <= ST_HOLD;
                ST_HOLD:   if (hold_done) state <= ST_RELEASE;
                ST_RELEASE: if (xfer) begin
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    fwb_crc16 u_crc (
        .clk  (clk),
        .rst  (rst),
        .clr  ((state == ST_CRC_CLR) && xfer),
        .upd  ((state == ST_EXEC) && xfer),
        .word (src_word),
        .crc  (crc_val)
    );

    fwb_hold_timer #(.LIM(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .arm     ((state == ST_RST_ON) && xfer),
        .run     (state == ST_HOLD),
        .expired (hold_done)
    );

    // checker: cycles since the reset-on write was accepted
    localparam int GAP_W = $clog2(HOLD_CYC + 2);
    logic [GAP_W-1:0] gap_cnt;
    always_ff @(posedge clk) begin
        if (rst || ((state == ST_RST_ON) && xfer)) gap_cnt <= '0;
        else if (gap_cnt != '1)                    gap_cnt <= gap_cnt + 1'b1;
    end

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata))); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        error |=> !error); // R10
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(done && error)); // R10
    AST_ALIGN_REJECT: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && start && misaligned) |=> (error && !bus_req)); // R1
    AST_SKIP_LOADED: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ID_RD) && xfer && (bus_rdata != 16'h0000)) |=> (done && !bus_req)); // R2
    AST_CRC_ABORT: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_CRC_RD) && xfer && (bus_rdata != crc_val)) |=> (error && !bus_req)); // R6
    AST_HOLD_MIN: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RELEASE) && bus_req) |-> (gap_cnt >= GAP_W'(HOLD_CYC))); // R8

endmodule

// File: tb/sim_fw_boot_seq.sv
module sim_fw_boot_seq;

    localparam int LEN_W    = 16;
    localparam int IDX_W    = LEN_W - 2;
    localparam int CLK_HZ   = 200_000_000;
    localparam int HOLD_US  = 2;
    localparam int HOLD_CYC = ((CLK_HZ + 999_999) / 1_000_000) * HOLD_US;
    localparam int LOGN     = 512;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [LEN_W-1:0] seg0_len = '0, seg1_len = '0;
    logic             src_seg;
    logic [IDX_W-1:0] src_idx;
    logic [31:0]      src_word;
    logic             bus_req, bus_we, bus_ack = 1'b0;
    logic [15:0]      bus_addr, bus_wdata, bus_rdata = '0;
    logic             done, error;

    int total = 0, bad = 0;
    logic [31:0] salt = 32'h1;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] wfun(logic [31:0] sl, logic s, int i);
        return (sl * 32'(i + 7)) ^ (s ? 32'hC3A5_96E1 : 32'h1B2D_4F60) ^
               {16'(i), 16'(~i)};
    endfunction

    assign src_word = wfun(salt, src_seg, int'(src_idx));

    fw_boot_seq #(.LEN_W(LEN_W), .CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US)) u0 (
        .clk(clk), .rst(rst), .start(start), .seg0_len(seg0_len),
        .seg1_len(seg1_len), .src_seg(src_seg), .src_idx(src_idx),
        .src_word(src_word), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .done(done), .error(error)
    );

    // byte-wise CRC-16 reference, poly 0x1021
    function automatic logic [15:0] ref_crc(logic [15:0] c, logic [31:0] w);
        logic [15:0] r = c;
        for (int b = 0; b < 4; b++) begin
            r ^= {w[31 - 8*b -: 8], 8'h00};
            for (int k = 0; k < 8; k++)
                r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // responder model
    logic        lg_we   [LOGN];
    logic [15:0] lg_addr [LOGN];
    logic [15:0] lg_data [LOGN];
    int          lg_cyc  [LOGN];
    int          lg_n = 0, cyc = 0, dly = 0, crc_rds = 0, cor_idx = -1;
    logic [15:0] fwid = 0, scv = 0, mcrc = 0, mhi = 0, mlo = 0;

    always @(negedge clk) begin
        cyc++;
        if (bus_ack) bus_ack = 1'b0;
        else if (bus_req && !rst) begin
            if (dly > 0) dly--;
            else begin
                if (lg_n < LOGN) begin
                    lg_we[lg_n] = bus_we; lg_addr[lg_n] = bus_addr;
                    lg_data[lg_n] = bus_wdata; lg_cyc[lg_n] = cyc;
                    lg_n++;
                end
                if (bus_we) begin
                    if (bus_addr == 16'h0200 && bus_wdata == 16'h1000) mcrc = 0;
                    if (bus_addr == 16'h0204) mhi = bus_wdata;
                    if (bus_addr == 16'h0205) mlo = bus_wdata;
                    if (bus_addr == 16'h0200 && bus_wdata == 16'hC000)
                        mcrc = ref_crc(mcrc, {mhi, mlo});
                end else begin
                    case (bus_addr)
                        16'h0020: bus_rdata = fwid;
                        16'h0000: bus_rdata = scv;
                        16'h0201: begin
                            bus_rdata = mcrc ^ ((crc_rds == cor_idx) ? 16'h0100 : 16'h0);
                            crc_rds++;
                        end
                        default:  bus_rdata = 16'hDEAD;
                    endcase
                end
                bus_ack = 1'b1;
                dly = $urandom % 3;
            end
        end
    end

    // pulse monitor
    int  done_cnt = 0, err_cnt = 0, wide = 0;
    logic pd = 0, pe = 0;
    always @(negedge clk) begin
        if (done)  done_cnt++;
        if (error) err_cnt++;
        if ((done && pd) || (error && pe) || (done && error)) wide++;
        pd = done; pe = error;
    end

    // expected sequence
    logic        ex_we   [LOGN];
    logic [15:0] ex_addr [LOGN];
    logic [15:0] ex_data [LOGN];
    int          ex_n = 0, ex_done = 0, ex_err = 0;

    task automatic push(logic we, logic [15:0] a, logic [15:0] d);
        ex_we[ex_n] = we; ex_addr[ex_n] = a; ex_data[ex_n] = d; ex_n++;
    endtask

    function automatic string tag(logic [15:0] a, logic [15:0] d);
        case (a)
            16'h0020: return "R2";
            16'hC001: return (d == 16'h0041) ? "R3" : "R8";
            16'h0202, 16'h0203: return "R4";
            16'h0200: return (d == 16'h1000) ? "R4" : "R5";
            16'h0204, 16'h0205: return "R5";
            16'h0201: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic build(int l0, int l1, int cor);
        ex_n = 0; ex_done = 0; ex_err = 0;
        if ((l0 % 4) != 0 || (l1 % 4) != 0) begin ex_err = 1; return; end
        push(0, 16'h0020, 0);
        if (fwid != 0) begin ex_done = 1; return; end
        push(1, 16'hC001, 16'h0041);
        for (int s = 0; s < 2; s++) begin
            push(1, 16'h0200, 16'h1000);
            push(1, 16'h0202, (s == 1) ? 16'h4000 : 16'h3FFE);
            push(1, 16'h0203, 16'h0000);
            for (int i = 0; i < ((s == 1) ? l1 : l0) / 4; i++) begin
                logic [31:0] w = wfun(salt, s[0], i);
                push(1, 16'h0204, w[31:16]);
                push(1, 16'h0205, w[15:0]);
                push(1, 16'h0200, 16'hC000);
            end
            push(0, 16'h0201, 0);
            if (cor == s) begin ex_err = 1; return; end
        end
        push(0, 16'h0000, 0);
        push(1, 16'h0000, scv & ~16'h8800);
        push(1, 16'hC001, 16'h8041);
        push(1, 16'hC001, 16'h0040);
        ex_done = 1;
    endtask

    task automatic run_case(string nm, logic [15:0] fw, int l0, int l1,
                            logic [15:0] sc, int cor, bit busy, logic [31:0] sl);
        int t = 0, ion = -1, irel = -1;
        logic err_imm;
        fwid = fw; scv = sc; cor_idx = cor; salt = sl;
        lg_n = 0; crc_rds = 0; mcrc = 0;
        build(l0, l1, cor);
        seg0_len = LEN_W'(l0); seg1_len = LEN_W'(l1);
        @(negedge clk); done_cnt = 0; err_cnt = 0; wide = 0;
        start = 1'b1;
        @(negedge clk); start = 1'b0; err_imm = error;
        if (busy) begin
            repeat (30) @(negedge clk);
            seg0_len = 16'd6;
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        while ((done_cnt + err_cnt) == 0 && t < 40000) begin @(negedge clk); t++; end
        chk(t < 40000, "R10", {nm, " timeout"}, t, 40000);
        repeat (20) @(negedge clk);
        if (ex_err && ex_n == 0)
            chk(err_imm == 1'b1, "R1", {nm, " error cycle after start"}, err_imm, 1);
        chk(lg_n == ex_n, tag(16'h0000, 0) == "" ? "R9" : "R9", {nm, " transaction count"}, lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            bit ok = (lg_we[i] == ex_we[i]) && (lg_addr[i] == ex_addr[i]) &&
                     (!ex_we[i] || lg_data[i] == ex_data[i]);
            chk(ok, tag(ex_addr[i], ex_data[i]), {nm, " transaction"},
                {lg_we[i], 15'(0), lg_addr[i]} ^ 32'(lg_data[i]) << 0 == 0 ? 0 :
                {lg_addr[i], lg_data[i]}, {ex_addr[i], ex_data[i]});
            if (lg_addr[i] == 16'hC001 && lg_data[i] == 16'h8041) ion = i;
            if (lg_addr[i] == 16'hC001 && lg_data[i] == 16'h0040) irel = i;
        end
        chk(done_cnt == ex_done, "R10", {nm, " done pulses"}, done_cnt, ex_done);
        chk(err_cnt == ex_err, ex_err ? "R6" : "R10", {nm, " error pulses"}, err_cnt, ex_err);
        chk(wide == 0, "R10", {nm, " pulse shape"}, wide, 0);
        if (ex_done && ion >= 0 && irel >= 0)
            chk((lg_cyc[irel] - lg_cyc[ion]) > HOLD_CYC, "R8", {nm, " reset hold"},
                lg_cyc[irel] - lg_cyc[ion], HOLD_CYC + 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R10", "reset done", done, 0);
        chk(error == 1'b0, "R10", "reset error", error, 0);
        chk(bus_req == 1'b0, "R9", "reset bus idle", bus_req, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_case("R2 firmware present", 16'h0102, 8, 8, 16'h0, -1, 0, 32'h11);
        run_case("R1 data len odd", 16'h0, 6, 8, 16'h0, -1, 0, 32'h12);
        run_case("R1 instr len odd", 16'h0, 8, 13, 16'h0, -1, 0, 32'h13);
        run_case("R7 full load", 16'h0, 8, 12, 16'hFFFF, -1, 0, 32'h9E37_79B9);
        run_case("R4 empty segments", 16'h0, 0, 0, 16'h8800, -1, 0, 32'h15);
        run_case("R6 data crc bad", 16'h0, 12, 8, 16'h1234, 0, 0, 32'h16);
        run_case("R6 instr crc bad", 16'h0, 12, 8, 16'h1234, 1, 0, 32'h17);
        run_case("R10 restart ignored", 16'h0, 32, 16, 16'h0F0F, -1, 1, 32'h18);
        for (int k = 0; k < 5; k++)
            run_case("R5 random load", 16'h0, ($urandom % 11) * 4, ($urandom % 11) * 4,
                     16'($urandom), -1, 0, $urandom);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule